// File: doc/BRIEF.md
# Cascadable Address-Decoding I/O Switch

This block routes single-master bus requests from a processor to a tree of I/O devices. Each switch level takes the upper select field of the incoming address and raises the strobe of exactly one downstream port. It passes the remaining low bits on as the port's internal register address. Write enable and write data go out to every port. Read data from the strobed port comes back to the processor.

The lowest-numbered ports of a switch lead to child switches of the same design. A child switch decodes the next select field of the forwarded address. This gives a cascade in which nearby devices sit on short paths and devices further down are reached through more levels. Decoding is purely combinational, so strobes, forwarded address and read return all settle in the same cycle as the request.

The top level is a fixed two-level tree with an 11-bit address and 2-bit select fields. The root has one child switch and three devices. The child switch has three devices and one spare slot.

Top module: `iosw_tree`

## Requirements
- R1: The root forwards req_addr[8:0] on root_addr and the child switch forwards req_addr[6:0] on leaf_addr, whether or not a strobe is raised.
- R2: Within each switch level at most one port strobe is high at any time.
- R3: While req_valid is low, every bit of dev_stb is low, whatever the address.
- R4: Root select code 00 (req_addr[10:9]) feeds the child switch. The child switch decodes req_addr[8:7], and its strobes can rise only when the root select is 00.
- R5: With req_valid high, root select codes 01, 10 and 11 raise dev_stb[0], dev_stb[1] and dev_stb[2]. Under root select 00, child codes 00, 01 and 10 raise dev_stb[3], dev_stb[4] and dev_stb[5].
- R6: An address whose bits [10:7] equal 0011 hits an unassigned slot: dev_stb stays all low and req_rdata is zero.
- R7: When dev_stb[i] is high, req_rdata equals dev_rdata[i] in the same cycle.
- R8: req_we and req_wdata appear unchanged on root_we/root_wdata and on leaf_we/leaf_wdata.
- R9: When no strobe is high, including when req_valid is low, req_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | Processor request active |
| req_we | input | 1 | Request is a write |
| req_addr | input | 11 | Full request address |
| req_wdata | input | 8 | Write data from processor |
| req_rdata | output | 8 | Read data returned to processor |
| dev_stb | output | 6 | Per-device strobe, in device order |
| root_addr | output | 9 | Low address bits forwarded to root-level devices |
| root_we | output | 1 | Write enable to root-level devices |
| root_wdata | output | 8 | Write data to root-level devices |
| leaf_addr | output | 7 | Low address bits forwarded to child-level devices |
| leaf_we | output | 1 | Write enable to child-level devices |
| leaf_wdata | output | 8 | Write data to child-level devices |
| dev_rdata | input | 6x8 | Read data from each device, packed by device index |

## Verification
All 2048 addresses are swept with the request valid and the write flag alternating. This separates every root slot, every child slot and the spare 0011 slot, and shows that only one strobe rises per address. Idle vectors with nonzero addresses show that the valid qualifier alone gates every strobe and the read return. A second sweep is run with an inverted device read-data pattern. It tells apart a return that follows the strobed device from one stuck on a fixed source or on a neighbouring port.

// File: rtl/iosw_pkg.sv
package iosw_pkg;

  localparam int IOSW_ADDR_W = 11;
  localparam int IOSW_SEL_W  = 2;
  localparam int IOSW_DATA_W = 8;

  typedef enum logic [1:0] {
    SLOT_CHILD = 2'd0,
    SLOT_IO    = 2'd1,
    SLOT_NONE  = 2'd2
  } slot_kind_e;

  // Lowest ports go to child switches, then devices, then spares.
  function automatic slot_kind_e slot_kind(int idx, int n_child, int n_io);
    if (idx < n_child)             return SLOT_CHILD;
    else if (idx < n_child + n_io) return SLOT_IO;
    else                           return SLOT_NONE;
  endfunction

endpackage

// File: rtl/iosw_decoder.sv
module iosw_decoder #(
  parameter int SEL_W      = 2,
  parameter int N_ASSIGNED = 4,
  localparam int N_PORT    = 1 << SEL_W
) (
  input  logic             valid,
  input  logic [SEL_W-1:0] sel,
  output logic             hit,
  output logic [N_PORT-1:0] stb
);

  always_comb begin
    hit = valid && (32'(sel) < N_ASSIGNED);
    stb = '0;
    if (hit) stb[sel] = 1'b1;
  end

endmodule

// File: rtl/iosw_rdmux.sv
module iosw_rdmux #(
  parameter int SEL_W  = 2,
  parameter int DATA_W = 8,
  localparam int N_PORT = 1 << SEL_W
) (
  input  logic                           hit,
  input  logic [SEL_W-1:0]               sel,
  input  logic [N_PORT-1:0][DATA_W-1:0]  port_rdata,
  output logic [DATA_W-1:0]              rdata
);

  always_comb begin
    rdata = '0;
    if (hit) rdata = port_rdata[sel];
  end

endmodule

// File: rtl/iosw_switch.sv
module iosw_switch
  import iosw_pkg::*;
#(
  parameter int ADDR_W  = IOSW_ADDR_W,
  parameter int SEL_W   = IOSW_SEL_W,
  parameter int DATA_W  = IOSW_DATA_W,
  parameter int N_CHILD = 1,
  parameter int N_IO    = 3,
  localparam int N_PORT = 1 << SEL_W,
  localparam int FWD_W  = ADDR_W - SEL_W
) (
  input  logic                          in_valid,
  input  logic                          in_we,
  input  logic [ADDR_W-1:0]             in_addr,
  input  logic [DATA_W-1:0]             in_wdata,
  output logic [DATA_W-1:0]             in_rdata,
  output logic [N_PORT-1:0]             port_stb,
  output logic                          port_we,
  output logic [FWD_W-1:0]              port_addr,
  output logic [DATA_W-1:0]             port_wdata,
  input  logic [N_PORT-1:0][DATA_W-1:0] port_rdata
);

  localparam int N_ASSIGNED = N_CHILD + N_IO;

  logic [SEL_W-1:0] sel;
  logic             hit;

  assign sel        = in_addr[ADDR_W-1 -: SEL_W];
  assign port_addr  = in_addr[FWD_W-1:0];
  assign port_we    = in_we;
  assign port_wdata = in_wdata;

  iosw_decoder #(
    .SEL_W      (SEL_W),
    .N_ASSIGNED (N_ASSIGNED)
  ) u_dec (
    .valid (in_valid),
    .sel   (sel),
    .hit   (hit),
    .stb   (port_stb)
  );

  iosw_rdmux #(
    .SEL_W  (SEL_W),
    .DATA_W (DATA_W)
  ) u_mux (
    .hit        (hit),
    .sel        (sel),
    .port_rdata (port_rdata),
    .rdata      (in_rdata)
  );

  always_comb begin
    AST_ONE_STROBE: assert ($onehot0(port_stb)); // R2
    if (!in_valid) begin
      AST_IDLE_QUIET: assert (port_stb == '0); // R3
    end
    if (port_stb == '0) begin
      AST_RD_ZERO_UNSEL: assert (in_rdata == '0); // R9
    end else begin
      AST_RD_ROUTE: assert (in_rdata == port_rdata[sel]); // R7
    end
  end

  for (genvar k = 0; k < N_PORT; k++) begin : g_slot
    localparam slot_kind_e KIND = slot_kind(k, N_CHILD, N_IO);
    if (KIND == SLOT_NONE) begin : g_spare
      always_comb begin
        AST_SPARE_QUIET: assert (!port_stb[k]); // R6
      end
    end
  end

endmodule

// File: rtl/iosw_tree.sv
module iosw_tree
  import iosw_pkg::*;
#(
  parameter int ADDR_W  = IOSW_ADDR_W,
  parameter int SEL_W   = IOSW_SEL_W,
  parameter int DATA_W  = IOSW_DATA_W,
  parameter int ROOT_IO = 3,
  parameter int LEAF_IO = 3,
  localparam int N_DEV  = ROOT_IO + LEAF_IO,
  localparam int N_PORT = 1 << SEL_W,
  localparam int ROOT_FWD_W = ADDR_W - SEL_W,
  localparam int LEAF_FWD_W = ADDR_W - 2 * SEL_W
) (
  input  logic                         req_valid,
  input  logic                         req_we,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic [DATA_W-1:0]            req_rdata,
  output logic [N_DEV-1:0]             dev_stb,
  output logic [ROOT_FWD_W-1:0]        root_addr,
  output logic                         root_we,
  output logic [DATA_W-1:0]            root_wdata,
  output logic [LEAF_FWD_W-1:0]        leaf_addr,
  output logic                         leaf_we,
  output logic [DATA_W-1:0]            leaf_wdata,
  input  logic [N_DEV-1:0][DATA_W-1:0] dev_rdata
);

  localparam int ROOT_CHILD = 1;

  logic [N_PORT-1:0]             root_stb;
  logic [N_PORT-1:0][DATA_W-1:0] root_prd;
  logic [N_PORT-1:0]             leaf_stb;
  logic [N_PORT-1:0][DATA_W-1:0] leaf_prd;
  logic [DATA_W-1:0]             leaf_rdata;

  iosw_switch #(
    .ADDR_W  (ADDR_W),
    .SEL_W   (SEL_W),
    .DATA_W  (DATA_W),
    .N_CHILD (ROOT_CHILD),
    .N_IO    (ROOT_IO)
  ) u_root (
    .in_valid   (req_valid),
    .in_we      (req_we),
    .in_addr    (req_addr),
    .in_wdata   (req_wdata),
    .in_rdata   (req_rdata),
    .port_stb   (root_stb),
    .port_we    (root_we),
    .port_addr  (root_addr),
    .port_wdata (root_wdata),
    .port_rdata (root_prd)
  );

  iosw_switch #(
    .ADDR_W  (ROOT_FWD_W),
    .SEL_W   (SEL_W),
    .DATA_W  (DATA_W),
    .N_CHILD (0),
    .N_IO    (LEAF_IO)
  ) u_leaf (
    .in_valid   (root_stb[0]),
    .in_we      (root_we),
    .in_addr    (root_addr),
    .in_wdata   (root_wdata),
    .in_rdata   (leaf_rdata),
    .port_stb   (leaf_stb),
    .port_we    (leaf_we),
    .port_addr  (leaf_addr),
    .port_wdata (leaf_wdata),
    .port_rdata (leaf_prd)
  );

  // Root port wiring: child link first, then devices, then spares.
  for (genvar p = 0; p < N_PORT; p++) begin : g_root
    if (p < ROOT_CHILD) begin : g_child
      assign root_prd[p] = leaf_rdata;
    end else if (p < ROOT_CHILD + ROOT_IO) begin : g_dev
      assign root_prd[p]                 = dev_rdata[p - ROOT_CHILD];
      assign dev_stb[p - ROOT_CHILD]     = root_stb[p];
    end else begin : g_spare
      assign root_prd[p] = '0;
      always_comb begin
        AST_ROOT_SPARE: assert (!root_stb[p]); // R6
      end
    end
  end

  // Child switch wiring: devices first, spares after.
  for (genvar p = 0; p < N_PORT; p++) begin : g_leaf
    if (p < LEAF_IO) begin : g_dev
      assign leaf_prd[p]           = dev_rdata[ROOT_IO + p];
      assign dev_stb[ROOT_IO + p]  = leaf_stb[p];
    end else begin : g_spare
      assign leaf_prd[p] = '0;
      always_comb begin
        AST_LEAF_SPARE: assert (!leaf_stb[p]); // R6
      end
    end
  end

  always_comb begin
    if (leaf_stb != '0) begin
      AST_LEAF_UNDER_ROOT0: assert (root_stb[0]); // R4
    end
    AST_TREE_ONE_DEV: assert ($onehot0(dev_stb)); // R2
    AST_FWD_CHAIN: assert (leaf_addr == req_addr[LEAF_FWD_W-1:0]); // R1
  end

endmodule

// File: tb/sim_iosw_tree.sv
module sim_iosw_tree;

  localparam int CLK_P = 10;

  typedef struct {
    logic [5:0] stb;
    logic [8:0] ra;
    logic [6:0] la;
    logic [7:0] rd;
    logic       we;
    logic [7:0] wd;
    int         vec;
  } exp_t;

  logic             clk;
  logic             req_valid;
  logic             req_we;
  logic [10:0]      req_addr;
  logic [7:0]       req_wdata;
  logic [7:0]       req_rdata;
  logic [5:0]       dev_stb;
  logic [8:0]       root_addr;
  logic             root_we;
  logic [7:0]       root_wdata;
  logic [6:0]       leaf_addr;
  logic             leaf_we;
  logic [7:0]       leaf_wdata;
  logic [5:0][7:0]  dev_rdata;

  exp_t q[$];
  int   n_vec  = 0;
  int   n_miss = 0;
  bit   done   = 0;

  iosw_tree u0 (
    .req_valid  (req_valid),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_rdata  (req_rdata),
    .dev_stb    (dev_stb),
    .root_addr  (root_addr),
    .root_we    (root_we),
    .root_wdata (root_wdata),
    .leaf_addr  (leaf_addr),
    .leaf_we    (leaf_we),
    .leaf_wdata (leaf_wdata),
    .dev_rdata  (dev_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  // Reference model: R4/R5 mapping, R6 spare slot, R3 idle.
  function automatic int model_dev(logic v, logic [10:0] a);
    if (!v) return -1;
    if (a[10:9] != 2'b00) return int'(a[10:9]) - 1;
    if (a[8:7] == 2'b11) return -1;
    return 3 + int'(a[8:7]);
  endfunction

  task automatic apply(input logic v, input logic we, input logic [10:0] a,
                       input logic [7:0] wd);
    exp_t e;
    int   d;
    @(negedge clk);
    req_valid = v;
    req_we    = we;
    req_addr  = a;
    req_wdata = wd;
    d      = model_dev(v, a);
    e.stb  = (d < 0) ? 6'd0 : 6'(1 << d);
    e.rd   = (d < 0) ? 8'd0 : dev_rdata[d];
    e.ra   = a[8:0];
    e.la   = a[6:0];
    e.we   = we;
    e.wd   = wd;
    e.vec  = n_vec;
    n_vec++;
    q.push_back(e);
  endtask

  task automatic set_rdata(input bit invert);
    @(negedge clk);
    for (int i = 0; i < 6; i++)
      dev_rdata[i] = invert ? ~(8'(8'h11 * (i + 1))) : 8'(8'h11 * (i + 1));
  endtask

  // Monitor: outputs are combinational, so compare at the posedge
  // following the negedge where the vector was driven.
  initial begin
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (dev_stb !== e.stb) begin
          n_miss++;
          $display("FAIL R2/R3/R4/R5/R6 vec %0d addr %b stb got %b exp %b",
                   e.vec, req_addr, dev_stb, e.stb);
        end
        if (root_addr !== e.ra || leaf_addr !== e.la) begin
          n_miss++;
          $display("FAIL R1 vec %0d fwd got %h/%h exp %h/%h",
                   e.vec, root_addr, leaf_addr, e.ra, e.la);
        end
        if (req_rdata !== e.rd) begin
          n_miss++;
          $display("FAIL R7/R9 vec %0d rdata got %h exp %h", e.vec, req_rdata, e.rd);
        end
        if (root_we !== e.we || leaf_we !== e.we ||
            root_wdata !== e.wd || leaf_wdata !== e.wd) begin
          n_miss++;
          $display("FAIL R8 vec %0d we/wdata got %b%b/%h/%h exp %b/%h",
                   e.vec, root_we, leaf_we, root_wdata, leaf_wdata, e.we, e.wd);
        end
      end
    end
  end

  initial begin
    req_valid = 1'b0;
    req_we    = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    dev_rdata = '0;
    set_rdata(1'b0);

    // R3/R9: idle state, then idle with busy addresses.
    apply(1'b0, 1'b0, 11'h000, 8'h00);
    apply(1'b0, 1'b1, 11'h7FF, 8'hFF);
    apply(1'b0, 1'b0, 11'h200, 8'h3C);
    apply(1'b0, 1'b1, 11'h080, 8'hC3);

    // R5 root devices, R4 child devices, R6 spare 0011 slot.
    apply(1'b1, 1'b0, 11'b01_000000000, 8'h01);
    apply(1'b1, 1'b0, 11'b10_000000000, 8'h02);
    apply(1'b1, 1'b0, 11'b11_111111111, 8'h03);
    apply(1'b1, 1'b1, 11'b00_00_1010101, 8'h04);
    apply(1'b1, 1'b1, 11'b00_01_0101010, 8'h05);
    apply(1'b1, 1'b1, 11'b00_10_1111111, 8'h06);
    apply(1'b1, 1'b0, 11'b00_11_0000000, 8'h07);
    apply(1'b1, 1'b1, 11'b00_11_1111111, 8'h08);

    // R1/R2/R8: full sweep, write flag alternating.
    for (int a = 0; a < 2048; a++)
      apply(1'b1, a[0], 11'(a), 8'(a) ^ 8'h5A);

    // R7: inverted read data, sweep again.
    set_rdata(1'b1);
    for (int a = 0; a < 2048; a += 3)
      apply(1'b1, 1'b0, 11'(a), 8'(a));
    apply(1'b0, 1'b0, 11'h600, 8'h00);

    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog expired got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

endmodule